// File: doc/BRIEF.md
# Reset Sequencer with Cause Flags

This block merges every source of reset into one device reset and keeps three sticky cause flags that software reads to learn why the device last restarted. The sources are a power-on detect line, an external active-low reset pin, a brown-out comparator output, and a configuration-mismatch request from the integrity monitor. A regulator-enable strap gates brown-out detection. The pin only feeds this block: nothing inside ever drives it.

Short low pulses on the pin are filtered out, and so are brief supply dips. A qualified brown-out holds reset for as long as the supply stays low. When a brown-out, pin or mismatch reset ends, one shared power-up timer holds reset for a fixed number of further cycles, and so does power-on. If the supply dips again while that timer runs, the block goes straight back to brown-out hold and the timer starts over.

The flags are cleared by hardware only: the power-on flag and the brown-out flag by power-on, the brown-out flag by a brown-out reset, and the mismatch flag by a mismatch reset. Software can only set them back to 1, through a masked write.

Top module: `rstCauseSeq`

## Requirements
- R1: While `powerOnIn` is high, `deviceRst` is 1 at once, `porFlag` and `borFlag` are 0 and `cmFlag` is 1. `porFlag` never falls except on power-on.
- R2: A low level on `extRstN` lasting fewer than `FILT_LEN` cycles does not assert `deviceRst` and changes no flag.
- R3: A low level on `extRstN` lasting well beyond `FILT_LEN` cycles asserts `deviceRst` for as long as the pin stays low, and leaves all three flags unchanged.
- R4: `supplyLow` high for fewer than `BOR_QUAL` cycles does not assert `deviceRst` and leaves `borFlag` unchanged.
- R5: `supplyLow` high for longer than `BOR_QUAL` cycles, with `regEnable` high, asserts `deviceRst` and clears `borFlag`. Reset is held while `supplyLow` stays high.
- R6: After a brown-out, pin or mismatch cause ends, and after power-on, `deviceRst` stays 1 for about `PWRT_LEN` further cycles. It then falls, in step with `clk`.
- R7: If `supplyLow` rises while the power-up timer runs, the block returns at once to brown-out hold, with no qualification delay. `borFlag` is cleared again, and the full timer restarts once the supply recovers.
- R8: While `regEnable` is 0, `supplyLow` never causes a reset and never clears `borFlag`.
- R9: A high level on `cfgMismatch` clears `cmFlag`, leaves `porFlag` and `borFlag` unchanged, and resets the device through the power-up timer.
- R10: A cycle with `swWrEn` high sets each flag whose mask bit is 1 (bit 0 `porFlag`, bit 1 `borFlag`, bit 2 `cmFlag`). Mask bits that are 0 have no effect, and no flag rises without such a write.
- R11: When a software set and a hardware clear of the same flag fall in the same cycle, the flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| powerOnIn | input | 1 | Power-on detect, active high, asserts reset asynchronously |
| extRstN | input | 1 | External reset pin, active low, input only |
| supplyLow | input | 1 | Brown-out comparator output, 1 = supply below threshold |
| regEnable | input | 1 | Regulator-enable strap, 1 = brown-out detection active |
| cfgMismatch | input | 1 | Configuration-mismatch reset request, active high |
| swWrEn | input | 1 | Software flag-set strobe |
| swSetMask | input | 3 | Flags to set: bit 0 POR, bit 1 BOR, bit 2 CM |
| deviceRst | output | 1 | Device reset, active high |
| porFlag | output | 1 | Power-on cause flag, 0 after power-on |
| borFlag | output | 1 | Brown-out cause flag, 0 after brown-out or power-on |
| cmFlag | output | 1 | Mismatch cause flag, 0 after a mismatch reset |

## Verification
Each source is driven twice: once just under its filter or qualification window and once well past it. This separates an ignored event from a real reset, and each real reset must clear only its own flag. A brown-out with a clean recovery is set against one that dips again partway through the power-up timer, so a timer that keeps counting shows up as an early release. The same long dip is repeated with the strap off. A mismatch request is timed to overlap software sets of the mismatch flag exactly, so the priority between hardware clear and software set decides the final value.

// File: rtl/rstCausePkg.sv
package rstCausePkg;

  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_RUN   = 2'd1,
    ST_BROWN = 2'd2,
    ST_PIN   = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClr;
    logic tmrRun;
    logic clrBor;
    logic clrCm;
  } ctrlStrobes_t;

  // qualified conditions from datapath to control
  typedef struct packed {
    logic pinQual;
    logic brownQual;
    logic brownNow;
    logic cmReq;
    logic tmrDone;
  } dpStatus_t;

  localparam int FLAG_POR = 0;
  localparam int FLAG_BOR = 1;
  localparam int FLAG_CM  = 2;
  localparam int FLAG_N   = 3;

endpackage

// File: rtl/rstCauseSync.sv
module rstCauseSync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RST_VAL;
    else       stage[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= RST_VAL;
        else       stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/rstCauseDatapath.sv
module rstCauseDatapath
  import rstCausePkg::*;
#(
  parameter int FILT_LEN = 8,
  parameter int BOR_QUAL = 12,
  parameter int PWRT_LEN = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              extRstN,
  input  logic              supplyLow,
  input  logic              regEnable,
  input  logic              cfgMismatch,
  input  logic              swWrEn,
  input  logic [FLAG_N-1:0] swSetMask,
  input  ctrlStrobes_t      strobes,
  output dpStatus_t         status,
  output logic [FLAG_N-1:0] flags
);

  localparam int FILT_W = $clog2(FILT_LEN + 1);
  localparam int QUAL_W = $clog2(BOR_QUAL + 1);
  localparam int TMR_W  = $clog2(PWRT_LEN + 1);
  localparam logic [FILT_W-1:0] FILT_MAX = FILT_W'(FILT_LEN);
  localparam logic [QUAL_W-1:0] QUAL_MAX = QUAL_W'(BOR_QUAL);
  localparam logic [TMR_W-1:0]  TMR_MAX  = TMR_W'(PWRT_LEN);

  // bit 2 pin (idles high), bit 1 supply, bit 0 mismatch
  logic [2:0] syncOut;
  rstCauseSync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rstN(porN),
    .d   ({extRstN, supplyLow, cfgMismatch}),
    .q   (syncOut)
  );

  logic pinLowSync, brownSync, cmSync;
  assign pinLowSync = ~syncOut[2];
  assign brownSync  = syncOut[1] & regEnable;
  assign cmSync     = syncOut[0];

  // pin glitch filter: saturating count of consecutive low cycles
  logic [FILT_W-1:0] pinCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                            pinCnt <= '0;
    else if (!pinLowSync)                 pinCnt <= '0;
    else if (pinCnt != FILT_MAX)          pinCnt <= pinCnt + 1'b1;
  end

  // brown-out qualification counter
  logic [QUAL_W-1:0] qualCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                            qualCnt <= '0;
    else if (!brownSync)                  qualCnt <= '0;
    else if (qualCnt != QUAL_MAX)         qualCnt <= qualCnt + 1'b1;
  end

  // power-up timer
  logic [TMR_W-1:0] tmrCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                                    tmrCnt <= '0;
    else if (strobes.tmrClr)                      tmrCnt <= '0;
    else if (strobes.tmrRun && tmrCnt != TMR_MAX) tmrCnt <= tmrCnt + 1'b1;
  end

  assign status.pinQual   = pinLowSync && (pinCnt == FILT_MAX);
  assign status.brownQual = brownSync && (qualCnt == QUAL_MAX);
  assign status.brownNow  = brownSync;
  assign status.cmReq     = cmSync;
  assign status.tmrDone   = (tmrCnt == TMR_MAX);

  // cause flags: hardware clear has priority over software set
  logic [FLAG_N-1:0] hwClr;
  assign hwClr[FLAG_POR] = 1'b0;
  assign hwClr[FLAG_BOR] = strobes.clrBor;
  assign hwClr[FLAG_CM]  = strobes.clrCm;

  localparam logic [FLAG_N-1:0] FLAG_RST = FLAG_N'(1) << FLAG_CM;

  generate
    for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
      always_ff @(posedge clk or negedge porN) begin
        if (!porN)                         flags[f] <= FLAG_RST[f];
        else if (hwClr[f])                 flags[f] <= 1'b0;
        else if (swWrEn && swSetMask[f])   flags[f] <= 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/rstCauseCtrl.sv
module rstCauseCtrl
  import rstCausePkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         deviceRst
);

  seqState_t state, nextState;
  logic restart, clrBor, clrCm;

  always_comb begin
    nextState = state;
    restart   = 1'b0;
    clrBor    = 1'b0;
    clrCm     = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (status.brownQual) begin
          nextState = ST_BROWN;
          clrBor    = 1'b1;
        end else if (status.pinQual) begin
          nextState = ST_PIN;
        end else if (status.cmReq) begin
          nextState = ST_PWRUP;
          clrCm     = 1'b1;
          restart   = 1'b1;
        end
      end
      ST_PWRUP: begin
        if (status.brownNow) begin
          nextState = ST_BROWN;
          clrBor    = 1'b1;
        end else if (status.pinQual) begin
          nextState = ST_PIN;
        end else if (status.cmReq) begin
          clrCm     = 1'b1;
          restart   = 1'b1;
        end else if (status.tmrDone) begin
          nextState = ST_RUN;
        end
      end
      ST_BROWN: begin
        if (!status.brownNow) nextState = ST_PWRUP;
      end
      ST_PIN: begin
        if (status.brownQual) begin
          nextState = ST_BROWN;
          clrBor    = 1'b1;
        end else if (!status.pinQual) begin
          nextState = ST_PWRUP;
        end
      end
      default: nextState = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state     <= ST_PWRUP;
      deviceRst <= 1'b1;
    end else begin
      state     <= nextState;
      deviceRst <= (nextState != ST_RUN);
    end
  end

  assign strobes.tmrClr = (state != ST_PWRUP) || restart;
  assign strobes.tmrRun = (state == ST_PWRUP);
  assign strobes.clrBor = clrBor;
  assign strobes.clrCm  = clrCm;

endmodule

// File: rtl/rstCauseSeq.sv
module rstCauseSeq
  import rstCausePkg::*;
#(
  parameter int FILT_LEN = 8,
  parameter int BOR_QUAL = 12,
  parameter int PWRT_LEN = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       powerOnIn,
  input  logic       extRstN,
  input  logic       supplyLow,
  input  logic       regEnable,
  input  logic       cfgMismatch,
  input  logic       swWrEn,
  input  logic [2:0] swSetMask,
  output logic       deviceRst,
  output logic       porFlag,
  output logic       borFlag,
  output logic       cmFlag
);

  // power-on: asserted asynchronously, released through two flops
  logic [1:0] porSync;
  logic porN;
  always_ff @(posedge clk or posedge powerOnIn) begin
    if (powerOnIn) porSync <= 2'b00;
    else           porSync <= {porSync[0], 1'b1};
  end
  assign porN = porSync[1];

  ctrlStrobes_t strobes;
  dpStatus_t status;
  logic [FLAG_N-1:0] flags;

  rstCauseDatapath #(
    .FILT_LEN(FILT_LEN), .BOR_QUAL(BOR_QUAL),
    .PWRT_LEN(PWRT_LEN), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .porN(porN), .extRstN(extRstN), .supplyLow(supplyLow),
    .regEnable(regEnable), .cfgMismatch(cfgMismatch), .swWrEn(swWrEn),
    .swSetMask(swSetMask), .strobes(strobes), .status(status), .flags(flags)
  );

  rstCauseCtrl u_ctrl (
    .clk(clk), .porN(porN), .status(status),
    .strobes(strobes), .deviceRst(deviceRst)
  );

  assign porFlag = flags[FLAG_POR];
  assign borFlag = flags[FLAG_BOR];
  assign cmFlag  = flags[FLAG_CM];

endmodule

// File: rtl/rstCauseChk.sv
module rstCauseChk (
  input logic       clk,
  input logic       porN,
  input logic       regEnable,
  input logic       swWrEn,
  input logic [2:0] swSetMask,
  input logic       deviceRst,
  input logic       porFlag,
  input logic       borFlag,
  input logic       cmFlag
);

  assert_por_sticky_R1: assert property (@(posedge clk) disable iff (!porN)
    porFlag |=> porFlag);

  assert_bor_clear_in_rst_R5: assert property (@(posedge clk) disable iff (!porN)
    $fell(borFlag) |-> deviceRst);

  assert_bor_off_strap_R8: assert property (@(posedge clk) disable iff (!porN)
    (!regEnable && !$past(regEnable) && !$past(regEnable, 2)) |-> !$fell(borFlag));

  assert_cm_clear_in_rst_R9: assert property (@(posedge clk) disable iff (!porN)
    $fell(cmFlag) |-> deviceRst);

  assert_sw_sets_por_R10: assert property (@(posedge clk) disable iff (!porN)
    (swWrEn && swSetMask[0]) |=> porFlag);

  assert_cm_rise_only_sw_R10: assert property (@(posedge clk) disable iff (!porN)
    (!cmFlag && !(swWrEn && swSetMask[2])) |=> !cmFlag);

endmodule

bind rstCauseSeq rstCauseChk u_chk (.*);

// File: tb/rstCauseSeq_bench.sv
module rstCauseSeq_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic powerOnIn, extRstN, supplyLow, regEnable, cfgMismatch, swWrEn;
  logic [2:0] swSetMask;
  logic deviceRst, porFlag, borFlag, cmFlag;

  rstCauseSeq #(.FILT_LEN(8), .BOR_QUAL(12), .PWRT_LEN(32), .SYNC_STAGES(2)) u_rstCauseSeq (
    .clk(clk), .powerOnIn(powerOnIn), .extRstN(extRstN), .supplyLow(supplyLow),
    .regEnable(regEnable), .cfgMismatch(cfgMismatch), .swWrEn(swWrEn),
    .swSetMask(swSetMask), .deviceRst(deviceRst), .porFlag(porFlag),
    .borFlag(borFlag), .cmFlag(cmFlag)
  );

  typedef struct {
    string      req;
    logic [3:0] exp;   // {deviceRst, cmFlag, borFlag, porFlag}
  } item_t;

  item_t expQ[$];
  event pushEv;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectNow(input string req, input logic [3:0] exp);
    item_t it;
    it.req = req;
    it.exp = exp;
    expQ.push_back(it);
    ->pushEv;
  endtask

  task automatic swSet(input logic [2:0] mask);
    swWrEn = 1'b1;
    swSetMask = mask;
    cyc(1);
    swWrEn = 1'b0;
    swSetMask = 3'b000;
  endtask

  // monitor: compares queued expectations against the ports
  initial begin
    forever begin
      @(pushEv);
      while (expQ.size() > 0) begin
        item_t it;
        logic [3:0] act;
        it = expQ.pop_front();
        act = {deviceRst, cmFlag, borFlag, porFlag};
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: {rst,cm,bor,por} actual=%b expected=%b at %0t",
                   it.req, act, it.exp, $time);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    powerOnIn = 1'b1; extRstN = 1'b1; supplyLow = 1'b0; regEnable = 1'b1;
    cfgMismatch = 1'b0; swWrEn = 1'b0; swSetMask = 3'b000;

    // R1: power-on state
    cyc(3);
    expectNow("R1 power-on state", 4'b1100);
    powerOnIn = 1'b0;
    cyc(20);
    expectNow("R6 power-up timer after power-on", 4'b1100);
    cyc(40);
    expectNow("R1 released, flags kept", 4'b0100);

    // R10: masked software set
    swSet(3'b011);
    cyc(1);
    expectNow("R10 software set por+bor", 4'b0111);

    // R2: short pin pulse ignored
    extRstN = 1'b0; cyc(4); extRstN = 1'b1;
    cyc(20);
    expectNow("R2 short pin pulse ignored", 4'b0111);

    // R3: long pin low
    extRstN = 1'b0; cyc(20);
    expectNow("R3 pin reset held, flags kept", 4'b1111);
    extRstN = 1'b1; cyc(10);
    expectNow("R6 timer after pin release", 4'b1111);
    cyc(40);
    expectNow("R6 release after pin reset", 4'b0111);

    // R4: short dip ignored
    supplyLow = 1'b1; cyc(6); supplyLow = 1'b0;
    cyc(20);
    expectNow("R4 short dip ignored", 4'b0111);

    // R5: qualified brown-out
    supplyLow = 1'b1; cyc(30);
    expectNow("R5 brown-out reset clears bor", 4'b1101);
    cyc(10); supplyLow = 1'b0; cyc(20);
    expectNow("R6 timer after brown-out", 4'b1101);
    cyc(30);
    expectNow("R6 release after brown-out", 4'b0101);

    // R7: re-dip during timer restarts it
    swSet(3'b010);
    cyc(1);
    expectNow("R10 software set bor", 4'b0111);
    supplyLow = 1'b1; cyc(40);
    supplyLow = 1'b0; cyc(10);
    supplyLow = 1'b1; cyc(2);
    supplyLow = 1'b0; cyc(25);
    expectNow("R7 re-dip restarts timer", 4'b1101);
    cyc(40);
    expectNow("R7 release after restarted timer", 4'b0101);

    // R8: strap off disables brown-out
    swSet(3'b010);
    regEnable = 1'b0;
    supplyLow = 1'b1; cyc(40);
    expectNow("R8 no brown-out with strap off", 4'b0111);
    supplyLow = 1'b0; cyc(3);
    regEnable = 1'b1; cyc(5);
    expectNow("R8 state after strap restored", 4'b0111);

    // R9: mismatch reset
    cfgMismatch = 1'b1; cyc(1); cfgMismatch = 1'b0;
    cyc(4);
    expectNow("R9 mismatch reset clears cm only", 4'b1011);
    cyc(50);
    expectNow("R9 release after mismatch", 4'b0011);

    // R11: clear beats set in the same cycle
    swSet(3'b100);
    cyc(1);
    expectNow("R10 software set cm", 4'b0111);
    cfgMismatch = 1'b1; swWrEn = 1'b1; swSetMask = 3'b100;
    cyc(3);
    cfgMismatch = 1'b0;
    cyc(2);
    swWrEn = 1'b0; swSetMask = 3'b000;
    cyc(2);
    expectNow("R11 hardware clear wins over set", 4'b1011);
    cyc(50);
    expectNow("R11 release, cm stays clear", 4'b0011);

    cyc(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule